// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral. It holds one or more 32-pin register sets, up to five, behind a plain 32-bit write/read register bus. For each pin it keeps a direction bit and an output latch. It also keeps a synchronized copy of the pad level and per-pin enables for rising-edge and falling-edge detection. Each pin has a sticky status bit that software clears by writing one.

Output bits and edge enables are changed through dedicated set and clear words, so one pin can be changed without a read-modify-write. Each 32-pin set is split into two 16-pin interrupt banks. Every bank drives one interrupt line, gated by its bit in a global bank-enable register. The first few pins of set 0 also bring their status bits out as ungated direct interrupt lines, for an interrupt controller that handles each of them alone.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every direction bit is 1 (input), and the output latch, edge enables, status bits and bank-enable register are 0. All interrupt outputs are low.
- R2: Set n occupies word offsets base+0x00 to base+0x24, with base = 0x10 + 0x28*n. Its direction word is at base+0x00. A direction bit of 1 makes the pin an input (pin_oe low) and 0 makes it an output (pin_oe high).
- R3: Writing a mask to base+0x08 sets the masked output bits, and writing to base+0x0C clears them; zero mask bits leave pins unchanged. base+0x04, base+0x08 and base+0x0C all read the output latch.
- R4: base+0x10 returns the pad level through a two-flop synchronizer, whatever the pin's direction, two clocks after the pad changes.
- R5: Writes to base+0x14 and base+0x18 set and clear rising enables, and writes to base+0x1C and base+0x20 set and clear falling enables. The set and clear words of each pair read back the current enables.
- R6: An enabled rising or falling edge on the synchronized level sets that pin's status bit (base+0x24) three clocks after the pad changes. Edges that are not enabled leave status unchanged.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R8: When an enabled edge and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R9: irq_bank[2n] is the OR of status bits 15:0 of set n, and irq_bank[2n+1] is the OR of bits 31:16. Each is ANDed with its bit in the bank-enable register at offset 0x08.
- R10: irq_pin[i] equals status bit i of set 0 and ignores the bank-enable register.
- R11: Offsets that map to no register, including the bytes 0x00 and 0x04 and any offset beyond the last set, read as zero and ignore writes. Writes to the input word are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_SETS*32 | Pad levels, asynchronous |
| pin_out | output | NUM_SETS*32 | Output latch |
| pin_oe | output | NUM_SETS*32 | Output enable, high where the pin is an output |
| irq_bank | output | 2*NUM_SETS | Gated per-bank interrupt lines |
| irq_pin | output | DIRECT_IRQS | Direct interrupt lines for the first pins of set 0 |

## Verification
The assertions assume that a write lasts exactly one cycle on bus_we with a stable address. They also assume that a pad level, once changed, is held long enough to pass through the synchronizer before the next change is judged. The stimulus drives bus signals and pads only on falling clock edges. It holds each pad value at least four cycles and drops the write strobe after a single rising edge. The race between an edge and a clearing write is produced on purpose by placing the write in the cycle the edge reaches the status register.

// File: rtl/gpio_bank_pkg.sv
// Package gpio_bank_pkg
// Shared word indices and address helpers for the banked GPIO controller.
// Assumes byte addressing with word-aligned registers.
package gpio_bank_pkg;

    localparam int WORDS_PER_SET = 10;
    localparam int SET_STRIDE    = 4 * WORDS_PER_SET;
    localparam int FIRST_SET     = 16;
    localparam logic [7:0] BANK_EN_ADDR = 8'h08;

    typedef enum logic [3:0] {
        W_DIR   = 4'd0,
        W_OUT   = 4'd1,
        W_OSET  = 4'd2,
        W_OCLR  = 4'd3,
        W_IN    = 4'd4,
        W_RSET  = 4'd5,
        W_RCLR  = 4'd6,
        W_FSET  = 4'd7,
        W_FCLR  = 4'd8,
        W_STAT  = 4'd9
    } word_e;

    // Byte base address of register set n.
    function automatic logic [7:0] set_base(input int n);
        return 8'(FIRST_SET + SET_STRIDE * n);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module gpio_sync
// Two-flop synchronizer for pad levels plus a one-cycle delayed copy,
// so edges can be found by comparing the two outputs.
// Assumes each input bit is an independent asynchronous level.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Purpose: two-stage synchronizer and delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign prev_o = prev_q;

    // R4: synchronized level lags the pad by exactly two clocks.
    assert_sync_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 (sync_q == $past(din, 2)));

endmodule

// File: rtl/gpio_reg_set.sv
// Module gpio_reg_set
// One 32-pin register set: direction, output latch with set/clear ports,
// input readback, rising/falling edge enables and sticky status.
// Assumes the parent decodes the address into a word index and a write
// strobe that is high for one cycle per write.
module gpio_reg_set
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_i,
    input  logic            wr_en,
    input  logic [3:0]      idx,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] rdata,
    output logic [PINS-1:0] dir_o,
    output logic [PINS-1:0] out_o,
    output logic [PINS-1:0] stat_o
);

    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] ren_q;
    logic [PINS-1:0] fen_q;
    logic [PINS-1:0] stat_q;
    logic [PINS-1:0] lvl;
    logic [PINS-1:0] lvl_prev;
    logic [PINS-1:0] evt;
    logic [PINS-1:0] w1c;

    gpio_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pad_i),
        .sync_o (lvl),
        .prev_o (lvl_prev)
    );

    // Purpose: enabled edge events from the synchronized level.
    always_comb begin
        evt = (lvl & ~lvl_prev & ren_q) | (~lvl & lvl_prev & fen_q);
    end

    // Purpose: mask of status bits a write-one-to-clear access targets.
    always_comb begin
        w1c = (wr_en && idx == W_STAT) ? wdata : '0;
    end

    // Purpose: direction and output latch updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (wr_en) begin
            case (idx)
                W_DIR:   dir_q <= wdata;
                W_OUT:   out_q <= wdata;
                W_OSET:  out_q <= out_q | wdata;
                W_OCLR:  out_q <= out_q & ~wdata;
                default: ;
            endcase
        end
    end

    // Purpose: rising and falling edge enable updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_q <= '0;
            fen_q <= '0;
        end else if (wr_en) begin
            case (idx)
                W_RSET:  ren_q <= ren_q | wdata;
                W_RCLR:  ren_q <= ren_q & ~wdata;
                W_FSET:  fen_q <= fen_q | wdata;
                W_FCLR:  fen_q <= fen_q & ~wdata;
                default: ;
            endcase
        end
    end

    // Purpose: sticky status; a new event outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~w1c) | evt;
    end

    // Purpose: read data for the selected word.
    always_comb begin
        case (idx)
            W_DIR:                 rdata = dir_q;
            W_OUT, W_OSET, W_OCLR: rdata = out_q;
            W_IN:                  rdata = lvl;
            W_RSET, W_RCLR:        rdata = ren_q;
            W_FSET, W_FCLR:        rdata = fen_q;
            W_STAT:                rdata = stat_q;
            default:               rdata = '0;
        endcase
    end

    assign dir_o  = dir_q;
    assign out_o  = out_q;
    assign stat_o = stat_q;

    // R3: a set-data write leaves every masked output bit high.
    assert_set_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == W_OSET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R3: a clear-data write leaves every masked output bit low.
    assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == W_OCLR) |=> ((out_q & $past(wdata)) == '0));

    // R6 and R8: every enabled edge leaves its status bit set, clear or not.
    assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(evt)) == $past(evt)));

    // R7: status bits not targeted by a clear never fall.
    assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~w1c)) == $past(stat_q & ~w1c)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module gpio_bank_ctrl
// Top of the banked GPIO controller: decodes the register bus across the
// register sets and the bank-enable word, and forms the gated bank
// interrupts and the direct per-pin interrupts.
// Assumes one-cycle write strobes and a stable address during reads.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_SETS    = 2,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int DIRECT_IRQS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_SETS*DATA_W-1:0] pin_in,
    output logic [NUM_SETS*DATA_W-1:0] pin_out,
    output logic [NUM_SETS*DATA_W-1:0] pin_oe,
    output logic [2*NUM_SETS-1:0]      irq_bank,
    output logic [DIRECT_IRQS-1:0]     irq_pin
);

    localparam int NUM_BANKS = 2 * NUM_SETS;
    localparam int HALF      = DATA_W / 2;
    localparam int SET_BYTES = 4 * WORDS_PER_SET;

    logic [NUM_BANKS-1:0] bank_en_q;
    logic [NUM_SETS-1:0]  set_hit;
    logic [DATA_W-1:0]    set_rd   [NUM_SETS];
    logic [DATA_W-1:0]    set_stat [NUM_SETS];
    logic                 en_hit;
    logic                 any_hit;

    assign en_hit = (bus_addr == ADDR_W'(BANK_EN_ADDR));

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        logic [ADDR_W-1:0] off;
        logic [DATA_W-1:0] dir_w;
        logic [DATA_W-1:0] out_w;

        // Purpose: offset of the access within this set and its hit flag.
        always_comb begin
            off        = bus_addr - ADDR_W'(set_base(g));
            set_hit[g] = (bus_addr >= ADDR_W'(set_base(g))) &&
                         (off < ADDR_W'(SET_BYTES)) && (off[1:0] == 2'b00);
        end

        gpio_reg_set #(.PINS(DATA_W)) u_set (
            .clk    (clk),
            .rst_n  (rst_n),
            .pad_i  (pin_in[g*DATA_W +: DATA_W]),
            .wr_en  (bus_we && set_hit[g]),
            .idx    (off[5:2]),
            .wdata  (bus_wdata),
            .rdata  (set_rd[g]),
            .dir_o  (dir_w),
            .out_o  (out_w),
            .stat_o (set_stat[g])
        );

        assign pin_out[g*DATA_W +: DATA_W] = out_w;
        assign pin_oe[g*DATA_W +: DATA_W]  = ~dir_w;
        assign irq_bank[2*g]   = (|set_stat[g][HALF-1:0])      & bank_en_q[2*g];
        assign irq_bank[2*g+1] = (|set_stat[g][DATA_W-1:HALF]) & bank_en_q[2*g+1];
    end

    assign any_hit = (|set_hit) || en_hit;

    // Purpose: global per-bank interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)               bank_en_q <= '0;
        else if (bus_we && en_hit) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
    end

    // Purpose: merge read data from whichever register the address selects.
    always_comb begin
        bus_rdata = '0;
        if (en_hit) bus_rdata[NUM_BANKS-1:0] = bank_en_q;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (set_hit[s]) bus_rdata = bus_rdata | set_rd[s];
        end
    end

    assign irq_pin = set_stat[0][DIRECT_IRQS-1:0];

    // R11: writes that hit no register leave the bank enables alone.
    assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !any_hit) |=> $stable(bank_en_q));

    // R11: reads that hit no register return zero.
    assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
// Bench for gpio_bank_ctrl: a vector table walked by one loop, then
// directed tests for the edge/clear race and a mid-run reset.
module gpio_bank_ctrl_tb;

    localparam int NS = 2;
    localparam int DW = 32;
    localparam int NB = 2 * NS;
    localparam int DI = 4;

    // ops: 0 write, 1 read-compare, 2 drive pads of set 0, 3 drive pads
    // of set 1, 4 compare irq_bank, 5 compare irq_pin
    localparam int NV = 47;
    localparam logic [46:0] VEC [NV] = '{
        {3'd1, 4'd1,  8'h10, 32'hFFFF_FFFF},  // R1 direction resets to inputs
        {3'd1, 4'd1,  8'h08, 32'h0000_0000},  // R1 bank enable zero
        {3'd1, 4'd1,  8'h34, 32'h0000_0000},  // R1 status zero
        {3'd0, 4'd2,  8'h10, 32'hFFFF_0000},  // R2 direction write
        {3'd1, 4'd2,  8'h10, 32'hFFFF_0000},  // R2
        {3'd0, 4'd3,  8'h18, 32'h0000_00F0},  // R3 set mask
        {3'd0, 4'd3,  8'h1C, 32'h0000_0030},  // R3 clear mask
        {3'd1, 4'd3,  8'h14, 32'h0000_00C0},  // R3 latch readback
        {3'd1, 4'd3,  8'h1C, 32'h0000_00C0},  // R3 clear word reads latch
        {3'd0, 4'd5,  8'h24, 32'h0001_0001},  // R5 set rising
        {3'd0, 4'd5,  8'h2C, 32'h0000_0003},  // R5 set falling
        {3'd0, 4'd5,  8'h28, 32'h0000_0001},  // R5 clear rising
        {3'd1, 4'd5,  8'h24, 32'h0001_0000},  // R5
        {3'd1, 4'd5,  8'h30, 32'h0000_0003},  // R5
        {3'd2, 4'd6,  8'h00, 32'h0001_0003},  // R6 rises on 0,1,16
        {3'd1, 4'd6,  8'h34, 32'h0001_0000},  // R6 only enabled rise
        {3'd2, 4'd6,  8'h00, 32'h0000_0000},  // R6 falls on 0,1,16
        {3'd1, 4'd6,  8'h34, 32'h0001_0003},  // R6
        {3'd5, 4'd10, 8'h00, 32'h0000_0003},  // R10 direct lines ungated
        {3'd4, 4'd9,  8'h00, 32'h0000_0000},  // R9 banks gated off
        {3'd1, 4'd4,  8'h20, 32'h0000_0000},  // R4
        {3'd0, 4'd9,  8'h08, 32'h0000_0001},  // R9
        {3'd4, 4'd9,  8'h00, 32'h0000_0001},  // R9
        {3'd0, 4'd9,  8'h08, 32'h0000_0003},  // R9
        {3'd4, 4'd9,  8'h00, 32'h0000_0003},  // R9
        {3'd0, 4'd7,  8'h34, 32'h0000_0001},  // R7 clear bit 0
        {3'd1, 4'd7,  8'h34, 32'h0001_0002},  // R7
        {3'd5, 4'd10, 8'h00, 32'h0000_0002},  // R10
        {3'd0, 4'd7,  8'h34, 32'h0001_0002},  // R7
        {3'd1, 4'd7,  8'h34, 32'h0000_0000},  // R7
        {3'd4, 4'd9,  8'h00, 32'h0000_0000},  // R9
        {3'd2, 4'd4,  8'h00, 32'h0000_0005},  // R4 pads on output pins
        {3'd1, 4'd4,  8'h20, 32'h0000_0005},  // R4
        {3'd1, 4'd6,  8'h34, 32'h0000_0000},  // R6 disabled edges ignored
        {3'd0, 4'd9,  8'h4C, 32'h8000_0000},  // R9 set 1 rising bit 31
        {3'd0, 4'd9,  8'h08, 32'h0000_000F},  // R9
        {3'd3, 4'd9,  8'h00, 32'h8000_0000},  // R9
        {3'd1, 4'd9,  8'h5C, 32'h8000_0000},  // R9 set 1 status
        {3'd4, 4'd9,  8'h00, 32'h0000_0008},  // R9 upper bank of set 1
        {3'd1, 4'd11, 8'h00, 32'h0000_0000},  // R11
        {3'd0, 4'd11, 8'h04, 32'hFFFF_FFFF},  // R11
        {3'd1, 4'd11, 8'h04, 32'h0000_0000},  // R11
        {3'd0, 4'd11, 8'h60, 32'hFFFF_FFFF},  // R11 past last set
        {3'd1, 4'd11, 8'h60, 32'h0000_0000},  // R11
        {3'd0, 4'd11, 8'h20, 32'hFFFF_FFFF},  // R11 input word write
        {3'd1, 4'd11, 8'h20, 32'h0000_0005},  // R11
        {3'd1, 4'd2,  8'h38, 32'hFFFF_FFFF}   // R2 set 1 base
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NS*DW-1:0]  pin_in = '0;
    logic [NS*DW-1:0]  pin_out;
    logic [NS*DW-1:0]  pin_oe;
    logic [NB-1:0]     irq_bank;
    logic [DI-1:0]     irq_pin;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_SETS(NS), .DATA_W(DW), .ADDR_W(8), .DIRECT_IRQS(DI)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_bank  (irq_bank),
        .irq_pin   (irq_pin)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [7:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(req, bus_rdata, exp);
    endtask

    task automatic drive_pads(input int s, input logic [DW-1:0] d);
        @(negedge clk);
        pin_in[s*DW +: DW] = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 interrupt lines and output enables after reset
        check("R1", {{(DW-NB){1'b0}}, irq_bank}, '0);
        check("R1", pin_oe[DW-1:0], '0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]    op;
            logic [3:0]    rq;
            logic [7:0]    ad;
            logic [DW-1:0] dt;
            string         tag;
            {op, rq, ad, dt} = VEC[v];
            tag = $sformatf("R%0d vec %0d", rq, v);
            case (op)
                3'd0: do_write(ad, dt);
                3'd1: do_read(tag, ad, dt);
                3'd2: drive_pads(0, dt);
                3'd3: drive_pads(1, dt);
                3'd4: begin @(negedge clk); #2; check(tag, {{(DW-NB){1'b0}}, irq_bank}, dt); end
                default: begin @(negedge clk); #2; check(tag, {{(DW-DI){1'b0}}, irq_pin}, dt); end
            endcase
        end

        // R2 output enables follow the direction word; R3 pads show the latch
        check("R2", pin_oe[DW-1:0], 32'h0000_FFFF);
        check("R3", pin_out[DW-1:0], 32'h0000_00C0);

        // R8: falling edge on pin 1 meets a clearing write in the same cycle
        do_write(8'h24, 32'h0000_0002);
        drive_pads(0, 32'h0000_0007);
        do_read("R8 setup", 8'h34, 32'h0000_0002);
        @(negedge clk);
        pin_in[DW-1:0] = 32'h0000_0005;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 32'h0000_0002; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #2;
        check("R8", bus_rdata, 32'h0000_0002);
        do_write(8'h34, 32'h0000_0002);
        do_read("R7", 8'h34, 32'h0000_0000);

        // R1: reset in the middle of a run restores every register
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read("R1", 8'h10, 32'hFFFF_FFFF);
        do_read("R1", 8'h14, 32'h0000_0000);
        do_read("R1", 8'h24, 32'h0000_0000);
        do_read("R1", 8'h08, 32'h0000_0000);
        do_read("R1", 8'h5C, 32'h0000_0000);
        check("R1", {{(DW-NB){1'b0}}, irq_bank}, '0);

        finish_run();
    end

endmodule